// File: doc/BRIEF.md
# Real-Time Clock Core with Polled Interrupt Flags

This block keeps a wall-clock calendar (seconds, minutes, hours, weekday, date, month, two-digit year) in byte-wide registers and advances it by one second each time the one-second strobe `upd_stb` pulses. Each field can be held in BCD or in plain binary. Hours can run on a 24-hour clock or on a 12-hour clock with a PM flag. A seconds/minutes/hours alarm can be set, and any of its fields can be made a wildcard.

Three events raise flags in a status register: the periodic tick, an alarm match and the end of an update. A flag is set whenever its event happens, whatever the enable bits hold, so software can poll for events with interrupts off. Only the active-low interrupt line depends on the enables. A read of the status register returns the flags and clears them at the same time. A square-wave output follows the periodic tick when software enables it.

Software reaches the block through a plain synchronous register port. There is no back-pressure: the port accepts a read or a write on every cycle. Read data comes out one cycle after the read request and holds until the next read.

Top module: `rtc_intr_core`

## Requirements
- R1: A set event sets its flag on the next clock edge even when every enable is off. The events are `rate_tick` for the periodic flag, `upd_stb` for the update flag and an alarm match for the alarm flag.
- R2: Reading address 12 returns the status byte one cycle later. The layout is bit 7 summary, bit 6 periodic, bit 5 alarm, bit 4 update, and bits 3..0 read 0. The same edge clears all three flags. If a flag's event arrives in the same cycle as the read, that flag stays set.
- R3: The summary bit is (periodic AND B[6]) OR (alarm AND B[5]) OR (update AND B[4]). `irq_n` is low exactly when the summary bit is 1.
- R4: Reset sets control B to 0x02. This clears every interrupt enable and the square-wave enable. Reset also clears all flags, so `irq_n` is high and `sqw_out` is low. The time resets to 00:00:00, weekday 1, date 01, month 01, year 00.
- R5: The weekday register at address 6 counts 1 to 7, with 1 meaning Sunday. On a day rollover it steps from 7 back to 1.
- R6: Control B bit 2 selects binary (1) or BCD (0) for storage and counting. For example, seconds step from 0x09 to 0x10 in BCD and from 0x09 to 0x0A in binary.
- R7: Each strobe adds one second and carries through minutes, hours, date, month and year. Month lengths are 30 days for months 4, 6, 9 and 11, and 31 days for the other months except February. February has 29 days when the year is divisible by 4 and 28 otherwise. The year wraps from 99 to 00.
- R8: Control B bit 1 set selects 24 hours (0..23). When it is clear, the hour byte holds 1..12 in bits 6..0 and PM in bit 7. In that mode 11 goes to 12 and toggles PM, 12 goes to 1, and the day advances on the step from 11 PM to 12 AM.
- R9: The alarm flag sets on a strobe when the new seconds, minutes and hours each equal their alarm byte (addresses 1, 3, 5). An alarm byte with bits 7:6 = 11 matches any value.
- R10: With B[3] set, `sqw_out` toggles on each `rate_tick`. With B[3] clear, it goes low within one cycle and stays low.
- R11: The address map is 0 sec, 1 alarm sec, 2 min, 3 alarm min, 4 hour, 5 alarm hour, 6 weekday, 7 date, 8 month, 9 year, 10 control A, 11 control B, 12 status. Control A and control B read back what was written. Writes to the status register do nothing.
- R12: If a bus write to a time register lands in the same cycle as `upd_stb`, the written value is the one stored in that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write request, taken every cycle |
| bus_rd | input | 1 | Read request, taken every cycle |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| upd_stb | input | 1 | One-second update strobe, one cycle wide |
| rate_tick | input | 1 | Periodic-rate tick, one cycle wide |
| irq_n | output | 1 | Active-low interrupt request |
| sqw_out | output | 1 | Square-wave output |

## Verification
The bench polls the status register with every enable off. A design that gates the flags with their enables would read zero and fail there. It also reads the status register in the same cycle as an update strobe. A design that lets the clear win would lose that update event, and a design that never clears would return stale flags on a second read.

The calendar is pushed across each boundary: February 29 in a leap year, February 28 in another year, a 30-day month, the end of the year, the weekday wrap, and the 11 to 12 and 12 to 1 steps on the 12-hour clock. A wrong month table, an off-by-one limit or a missing BCD adjust would show up as a wrong date or digit. The remaining cases are alarm wildcards, a bus write that collides with a strobe, a write to the status register that must be ignored, and gating of the square wave.

// File: rtl/rtc_core_pkg.sv
`timescale 1ns/1ps
package rtc_core_pkg;
  localparam int DW     = 8;
  localparam int NUM_TF = 7;   // time fields
  localparam int NUM_AL = 3;   // alarm fields
  localparam int NUM_FL = 3;   // flags

  // time field indices
  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DOW = 3;
  localparam int F_DOM = 4;
  localparam int F_MON = 5;
  localparam int F_YR  = 6;

  // flag indices, order matches enable bits B[6:4]
  localparam int FL_UF = 0;
  localparam int FL_AF = 1;
  localparam int FL_PF = 2;

  localparam int ADR_CA = 10;
  localparam int ADR_CB = 11;
  localparam int ADR_ST = 12;

  typedef struct packed {
    logic       wrap;
    logic [6:0] val;
  } step_t;

  function automatic int field_addr(int idx);
    case (idx)
      F_SEC:   return 0;
      F_MIN:   return 2;
      F_HR:    return 4;
      F_DOW:   return 6;
      F_DOM:   return 7;
      F_MON:   return 8;
      default: return 9;
    endcase
  endfunction

  function automatic int alarm_addr(int idx);
    return 2 * idx + 1;
  endfunction

  function automatic logic [7:0] field_rst(int idx);
    if (idx == F_DOW || idx == F_DOM || idx == F_MON) return 8'h01;
    return 8'h00;
  endfunction

  function automatic logic [6:0] to_bin(logic [7:0] v, logic bin_mode);
    logic [6:0] t;
    t = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    return bin_mode ? v[6:0] : t;
  endfunction

  function automatic logic [7:0] from_bin(logic [6:0] n, logic bin_mode);
    logic [6:0] q;
    logic [6:0] r;
    q = n / 7'd10;
    r = n % 7'd10;
    return bin_mode ? {1'b0, n} : {q[3:0], r[3:0]};
  endfunction

  function automatic step_t step_fld(logic [6:0] cur, logic [6:0] lo, logic [6:0] hi);
    step_t s;
    s.wrap = (cur >= hi);
    s.val  = s.wrap ? lo : cur + 7'd1;
    return s;
  endfunction

  function automatic logic [6:0] month_len(logic [6:0] mo, logic [6:0] yr);
    case (mo)
      7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_core_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bin_mode,
  input  logic                       h24,
  input  logic                       upd,
  input  logic [NUM_TF-1:0]          wr_sel,
  input  logic [DW-1:0]              wdata,
  output logic [NUM_TF-1:0][DW-1:0]  tm,
  output logic [NUM_TF-1:0][DW-1:0]  tm_adv
);
  logic [6:0] sb, mb, hb, dwb, dmb, mob, yrb;
  step_t      ss, ms, hs, ds, dms, mos, ys;
  logic [6:0] h12_val;
  logic       h12_pm, h12_day;
  logic [7:0] hr_next;
  logic       c_min, c_hr, c_day, c_mon, c_yr, day_wrap;

  always_comb begin
    sb  = to_bin(tm[F_SEC], bin_mode);
    mb  = to_bin(tm[F_MIN], bin_mode);
    hb  = to_bin(h24 ? tm[F_HR] : {1'b0, tm[F_HR][6:0]}, bin_mode);
    dwb = to_bin(tm[F_DOW], bin_mode);
    dmb = to_bin(tm[F_DOM], bin_mode);
    mob = to_bin(tm[F_MON], bin_mode);
    yrb = to_bin(tm[F_YR],  bin_mode);

    ss  = step_fld(sb, 7'd0, 7'd59);
    ms  = step_fld(mb, 7'd0, 7'd59);
    hs  = step_fld(hb, 7'd0, 7'd23);
    ds  = step_fld(dwb, 7'd1, 7'd7);
    dms = step_fld(dmb, 7'd1, month_len(mob, yrb));
    mos = step_fld(mob, 7'd1, 7'd12);
    ys  = step_fld(yrb, 7'd0, 7'd99);

    // 12-hour sequencing: 11 -> 12 flips PM, 12 -> 1 keeps it
    h12_pm  = tm[F_HR][7];
    h12_day = 1'b0;
    if (hb == 7'd11) begin
      h12_val = 7'd12;
      h12_pm  = ~tm[F_HR][7];
      h12_day = tm[F_HR][7];
    end else if (hb >= 7'd12) begin
      h12_val = 7'd1;
    end else begin
      h12_val = hb + 7'd1;
    end

    if (h24) begin
      hr_next  = from_bin(hs.val, bin_mode);
      day_wrap = hs.wrap;
    end else begin
      hr_next  = {h12_pm, from_bin(h12_val, bin_mode)[6:0]};
      day_wrap = h12_day;
    end

    c_min = ss.wrap;
    c_hr  = c_min & ms.wrap;
    c_day = c_hr & day_wrap;
    c_mon = c_day & dms.wrap;
    c_yr  = c_mon & mos.wrap;

    tm_adv[F_SEC] = from_bin(ss.val, bin_mode);
    tm_adv[F_MIN] = c_min ? from_bin(ms.val, bin_mode)  : tm[F_MIN];
    tm_adv[F_HR]  = c_hr  ? hr_next                      : tm[F_HR];
    tm_adv[F_DOW] = c_day ? from_bin(ds.val, bin_mode)  : tm[F_DOW];
    tm_adv[F_DOM] = c_day ? from_bin(dms.val, bin_mode) : tm[F_DOM];
    tm_adv[F_MON] = c_mon ? from_bin(mos.val, bin_mode) : tm[F_MON];
    tm_adv[F_YR]  = c_yr  ? from_bin(ys.val, bin_mode)  : tm[F_YR];
  end

  for (genvar i = 0; i < NUM_TF; i++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tm[i] <= field_rst(i);
      else if (wr_sel[i]) tm[i] <= wdata;
      else if (upd)       tm[i] <= tm_adv[i];
    end
  end

  AST_DOW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_sel[F_DOW] && tm[F_DOW] >= 8'd1 && tm[F_DOW] <= 8'd7)
      |=> (tm[F_DOW] >= 8'd1 && tm[F_DOW] <= 8'd7)); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && wr_sel[F_SEC]) |=> (tm[F_SEC] == $past(wdata))); // R12
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
  import rtc_core_pkg::*;
(
  input  logic [NUM_AL-1:0][DW-1:0] cand,
  input  logic [NUM_AL-1:0][DW-1:0] alarm,
  output logic                      hit
);
  logic [NUM_AL-1:0] fld_ok;

  for (genvar i = 0; i < NUM_AL; i++) begin : g_cmp
    assign fld_ok[i] = (alarm[i][7:6] == 2'b11) || (alarm[i] == cand[i]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/rtc_irq_flags.sv
`timescale 1ns/1ps
module rtc_irq_flags
  import rtc_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FL-1:0] set_ev,
  input  logic              clr,
  input  logic [NUM_FL-1:0] enable,
  output logic [NUM_FL-1:0] flags,
  output logic              summary
);
  for (genvar i = 0; i < NUM_FL; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (set_ev[i]) flags[i] <= 1'b1;
      else if (clr)       flags[i] <= 1'b0;
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]); // R1
  end

  assign summary = |(flags & enable);
endmodule

// File: rtl/rtc_intr_core.sv
`timescale 1ns/1ps
module rtc_intr_core
  import rtc_core_pkg::*;
#(
  parameter int          AW         = 4,
  parameter logic [7:0]  CTRL_A_RST = 8'h00,
  parameter logic [7:0]  CTRL_B_RST = 8'h02
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic          upd_stb,
  input  logic          rate_tick,
  output logic          irq_n,
  output logic          sqw_out
);
  logic [NUM_TF-1:0][DW-1:0] tm, tm_adv;
  logic [NUM_AL-1:0][DW-1:0] alarm_q, alarm_cand;
  logic [NUM_TF-1:0]         tm_wr;
  logic [DW-1:0]             ctrl_a, ctrl_b, rd_mux, stat_byte;
  logic [NUM_FL-1:0]         flags, set_ev;
  logic                      summary, alarm_hit, st_read, sqw_q;

  // ---- write decode ----
  for (genvar i = 0; i < NUM_TF; i++) begin : g_twr
    assign tm_wr[i] = bus_wr && (bus_addr == AW'(field_addr(i)));
  end

  for (genvar j = 0; j < NUM_AL; j++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alarm_q[j] <= '0;
      else if (bus_wr && bus_addr == AW'(alarm_addr(j))) alarm_q[j] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a <= CTRL_A_RST;
      ctrl_b <= CTRL_B_RST;
    end else if (bus_wr) begin
      if (bus_addr == AW'(ADR_CA)) ctrl_a <= bus_wdata;
      if (bus_addr == AW'(ADR_CB)) ctrl_b <= bus_wdata;
    end
  end

  // ---- calendar ----
  rtc_calendar i_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .bin_mode (ctrl_b[2]),
    .h24      (ctrl_b[1]),
    .upd      (upd_stb),
    .wr_sel   (tm_wr),
    .wdata    (bus_wdata),
    .tm       (tm),
    .tm_adv   (tm_adv)
  );

  // ---- alarm compare on the time the strobe produces ----
  assign alarm_cand[0] = tm_adv[F_SEC];
  assign alarm_cand[1] = tm_adv[F_MIN];
  assign alarm_cand[2] = tm_adv[F_HR];

  rtc_alarm_match i_alm (
    .cand  (alarm_cand),
    .alarm (alarm_q),
    .hit   (alarm_hit)
  );

  // ---- flags ----
  assign st_read       = bus_rd && (bus_addr == AW'(ADR_ST));
  assign set_ev[FL_UF] = upd_stb;
  assign set_ev[FL_AF] = upd_stb && alarm_hit;
  assign set_ev[FL_PF] = rate_tick;

  rtc_irq_flags i_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .clr     (st_read),
    .enable  (ctrl_b[6:4]),
    .flags   (flags),
    .summary (summary)
  );

  assign irq_n     = ~summary;
  assign stat_byte = {summary, flags, 4'h0};

  // ---- square wave ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sqw_q <= 1'b0;
    else if (!ctrl_b[3]) sqw_q <= 1'b0;
    else if (rate_tick)  sqw_q <= ~sqw_q;
  end
  assign sqw_out = sqw_q;

  // ---- read path ----
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_TF; i++)
      if (bus_addr == AW'(field_addr(i))) rd_mux = tm[i];
    for (int j = 0; j < NUM_AL; j++)
      if (bus_addr == AW'(alarm_addr(j))) rd_mux = alarm_q[j];
    if (bus_addr == AW'(ADR_CA)) rd_mux = ctrl_a;
    if (bus_addr == AW'(ADR_CB)) rd_mux = ctrl_b;
    if (bus_addr == AW'(ADR_ST)) rd_mux = stat_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // ---- checks ----
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_read && !upd_stb && !rate_tick) |=> (flags == '0)); // R2

  AST_STATUS_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_read |=> (bus_rdata[3:0] == 4'h0)); // R2

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_b[6:4] == 3'b000) |-> irq_n); // R3

  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_b[3] |=> !sqw_out); // R10

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(ADR_ST) && !bus_rd && !upd_stb && !rate_tick)
      |=> $stable(flags)); // R11
endmodule

// File: tb/test_rtc_intr_core.sv
`timescale 1ns/1ps
module test_rtc_intr_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, upd_stb = 1'b0, rate_tick = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_n, sqw_out;
  int         checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  rtc_intr_core i_rtc_intr_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .upd_stb(upd_stb), .rate_tick(rate_tick), .irq_n(irq_n), .sqw_out(sqw_out)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_STB = 2'd2, OP_TCK = 2'd3;
  localparam int NV = 64;
  // {requirement number, op, address, data / expected}
  localparam logic [17:0] VEC [NV] = '{
    {4'd6, OP_WR, 4'd11, 8'h02},                                  // R6 BCD, 24h
    {4'd7, OP_WR, 4'd0, 8'h58}, {4'd7, OP_WR, 4'd2, 8'h59},
    {4'd7, OP_WR, 4'd4, 8'h23}, {4'd5, OP_WR, 4'd6, 8'h07},
    {4'd7, OP_WR, 4'd7, 8'h28}, {4'd7, OP_WR, 4'd8, 8'h02},
    {4'd7, OP_WR, 4'd9, 8'h24},
    {4'd7, OP_STB, 4'd0, 8'h00},
    {4'd7, OP_RD, 4'd0, 8'h59},
    {4'd7, OP_STB, 4'd0, 8'h00},                                  // R7 Feb 28 -> 29 leap
    {4'd7, OP_RD, 4'd0, 8'h00}, {4'd7, OP_RD, 4'd4, 8'h00},
    {4'd5, OP_RD, 4'd6, 8'h01}, {4'd7, OP_RD, 4'd7, 8'h29},
    {4'd7, OP_RD, 4'd8, 8'h02},
    {4'd7, OP_WR, 4'd0, 8'h59}, {4'd7, OP_WR, 4'd2, 8'h59},
    {4'd7, OP_WR, 4'd4, 8'h23},
    {4'd7, OP_STB, 4'd0, 8'h00},                                  // R7 Feb 29 -> Mar 1
    {4'd7, OP_RD, 4'd7, 8'h01}, {4'd7, OP_RD, 4'd8, 8'h03},
    {4'd7, OP_WR, 4'd9, 8'h23}, {4'd7, OP_WR, 4'd8, 8'h02},
    {4'd7, OP_WR, 4'd7, 8'h28}, {4'd7, OP_WR, 4'd0, 8'h59},
    {4'd7, OP_WR, 4'd2, 8'h59}, {4'd7, OP_WR, 4'd4, 8'h23},
    {4'd7, OP_STB, 4'd0, 8'h00},                                  // R7 non-leap Feb 28 -> Mar 1
    {4'd7, OP_RD, 4'd7, 8'h01}, {4'd7, OP_RD, 4'd8, 8'h03},
    {4'd6, OP_WR, 4'd0, 8'h09}, {4'd6, OP_STB, 4'd0, 8'h00},
    {4'd6, OP_RD, 4'd0, 8'h10},                                   // R6 BCD digit carry
    {4'd7, OP_WR, 4'd9, 8'h99}, {4'd7, OP_WR, 4'd8, 8'h12},
    {4'd7, OP_WR, 4'd7, 8'h31}, {4'd7, OP_WR, 4'd0, 8'h59},
    {4'd7, OP_WR, 4'd2, 8'h59}, {4'd7, OP_WR, 4'd4, 8'h23},
    {4'd7, OP_STB, 4'd0, 8'h00},                                  // R7 year end
    {4'd7, OP_RD, 4'd9, 8'h00}, {4'd7, OP_RD, 4'd8, 8'h01},
    {4'd7, OP_RD, 4'd7, 8'h01},
    {4'd6, OP_WR, 4'd11, 8'h06}, {4'd6, OP_WR, 4'd0, 8'h09},
    {4'd6, OP_STB, 4'd0, 8'h00}, {4'd6, OP_RD, 4'd0, 8'h0A},      // R6 binary count
    {4'd6, OP_WR, 4'd0, 8'h3B}, {4'd6, OP_WR, 4'd2, 8'h3B},
    {4'd6, OP_WR, 4'd4, 8'h17}, {4'd6, OP_WR, 4'd7, 8'h1E},
    {4'd6, OP_WR, 4'd8, 8'h04},
    {4'd6, OP_STB, 4'd0, 8'h00},                                  // R6 binary 30-day month
    {4'd6, OP_RD, 4'd4, 8'h00}, {4'd7, OP_RD, 4'd7, 8'h01},
    {4'd7, OP_RD, 4'd8, 8'h05},
    {4'd5, OP_WR, 4'd11, 8'h02}, {4'd5, OP_WR, 4'd6, 8'h07},
    {4'd5, OP_WR, 4'd0, 8'h59}, {4'd5, OP_WR, 4'd2, 8'h59},
    {4'd5, OP_WR, 4'd4, 8'h23},
    {4'd5, OP_STB, 4'd0, 8'h00}, {4'd5, OP_RD, 4'd6, 8'h01}       // R5 weekday wrap
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic strobe();
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); rate_tick = 1'b1;
    @(negedge clk); rate_tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    chk("R4 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R4 sqw", {7'd0, sqw_out}, 8'h00);
    rd_chk("R4 ctrl B", 4'd11, 8'h02);
    rd_chk("R4 status", 4'd12, 8'h00);
    rd_chk("R4 weekday", 4'd6, 8'h01);

    // vector table
    for (int k = 0; k < NV; k++) begin
      case (VEC[k][13:12])
        OP_WR:  wr(VEC[k][11:8], VEC[k][7:0]);
        OP_STB: strobe();
        OP_TCK: tick();
        default: begin
          rd(VEC[k][11:8], v);
          chk($sformatf("R%0d vec %0d", VEC[k][17:14], k), v, VEC[k][7:0]);
        end
      endcase
    end

    // R8 12-hour clock, BCD
    wr(4'd11, 8'h00);
    wr(4'd4, 8'h11); wr(4'd2, 8'h59); wr(4'd0, 8'h59); strobe();
    rd_chk("R8 11AM->12PM", 4'd4, 8'h92);
    wr(4'd2, 8'h59); wr(4'd0, 8'h59); strobe();
    rd_chk("R8 12PM->1PM", 4'd4, 8'h81);
    wr(4'd7, 8'h10); wr(4'd4, 8'h91); wr(4'd2, 8'h59); wr(4'd0, 8'h59); strobe();
    rd_chk("R8 11PM->12AM", 4'd4, 8'h12);
    rd_chk("R8 day advance", 4'd7, 8'h11);
    wr(4'd2, 8'h59); wr(4'd0, 8'h59); strobe();
    rd_chk("R8 12AM->1AM", 4'd4, 8'h01);

    // R11 control registers
    wr(4'd10, 8'h5A);
    rd_chk("R11 ctrl A", 4'd10, 8'h5A);
    wr(4'd11, 8'h02);
    rd_chk("R11 ctrl B", 4'd11, 8'h02);

    // R1 / R2 flags with enables off
    rd(4'd12, v);
    strobe();
    chk("R3 irq_n idle", {7'd0, irq_n}, 8'h01);
    rd_chk("R1 update flag polled", 4'd12, 8'h10);
    rd_chk("R2 cleared by read", 4'd12, 8'h00);
    tick();
    chk("R3 irq_n periodic off", {7'd0, irq_n}, 8'h01);
    rd_chk("R1 periodic flag polled", 4'd12, 8'h40);

    // R3 enabled update interrupt
    wr(4'd11, 8'h12);
    strobe();
    chk("R3 irq_n asserted", {7'd0, irq_n}, 8'h00);
    rd_chk("R3 summary bit", 4'd12, 8'h90);
    chk("R2 irq_n released", {7'd0, irq_n}, 8'h01);

    // R9 alarm with wildcards
    wr(4'd11, 8'h02);
    wr(4'd1, 8'h05); wr(4'd3, 8'hC0); wr(4'd5, 8'hFF);
    wr(4'd0, 8'h04); strobe();
    rd_chk("R9 alarm hit", 4'd12, 8'h30);
    wr(4'd0, 8'h10); strobe();
    rd_chk("R9 alarm miss", 4'd12, 8'h10);
    wr(4'd11, 8'h22);
    wr(4'd0, 8'h04); strobe();
    chk("R3 alarm irq", {7'd0, irq_n}, 8'h00);
    rd_chk("R3 alarm summary", 4'd12, 8'hB0);

    // R2 read and update in the same cycle
    wr(4'd11, 8'h02);
    @(negedge clk); bus_addr = 4'd12; bus_rd = 1'b1; upd_stb = 1'b1;
    @(negedge clk); bus_rd = 1'b0; upd_stb = 1'b0;
    chk("R2 collide read value", bus_rdata, 8'h00);
    rd_chk("R2 collide flag kept", 4'd12, 8'h10);

    // R11 status ignores writes
    tick();
    wr(4'd12, 8'h00);
    rd_chk("R11 write 00 ignored", 4'd12, 8'h40);
    wr(4'd12, 8'hFF);
    rd_chk("R11 write FF ignored", 4'd12, 8'h00);

    // R12 write and strobe in the same cycle
    wr(4'd0, 8'h20);
    @(negedge clk); bus_addr = 4'd0; bus_wdata = 8'h45; bus_wr = 1'b1; upd_stb = 1'b1;
    @(negedge clk); bus_wr = 1'b0; upd_stb = 1'b0;
    rd_chk("R12 write wins", 4'd0, 8'h45);

    // R10 square wave
    tick();
    chk("R10 sqw disabled", {7'd0, sqw_out}, 8'h00);
    wr(4'd11, 8'h0A);
    tick();
    chk("R10 sqw toggle 1", {7'd0, sqw_out}, 8'h01);
    tick();
    chk("R10 sqw toggle 0", {7'd0, sqw_out}, 8'h00);
    tick();
    chk("R10 sqw toggle 1 again", {7'd0, sqw_out}, 8'h01);
    wr(4'd11, 8'h02);
    @(negedge clk);
    chk("R10 sqw gated low", {7'd0, sqw_out}, 8'h00);

    // R4 reset during operation
    wr(4'd11, 8'h7E);
    tick();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R4 irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk("R4 sqw after reset", {7'd0, sqw_out}, 8'h00);
    rd_chk("R4 ctrl B after reset", 4'd11, 8'h02);
    rd_chk("R4 status after reset", 4'd12, 8'h00);
    rd_chk("R4 seconds after reset", 4'd0, 8'h00);

    finish_run();
  end
endmodule